// File: doc/BRIEF.md
# ADC Sample Phase Sequencer

This block times the analog phases of one analog-to-digital conversion. It runs on a clock at twice the converter clock rate, so every count it makes is a half converter cycle. A start request begins a conversion. The block then drives the sample switch for a window whose length depends on a programmed duration and on whether the gain amplifier sits in the signal path. After the window it runs a convert phase of fixed length and waits for the converter core to report completion. At that point it emits a one-cycle result-ready strobe.

When the gain amplifier is used, the amplifier first tracks its input with the switch open. This track window is one full converter cycle longer than the programmed duration. The amplifier is then held while the switch closes onto its output, for a separately programmed hold duration. In burst mode the programmed sample duration has a lower limit, and the block raises an error flag when the setting is below it. In free-running mode a new conversion begins in the same cycle that the ready strobe is issued.

Top module: `adc_phase_seq`

## Requirements
- R1: After synchronous reset, `samp_sw`, `amp_hold` and `rdy` are low and no conversion is in progress.
- R2: With `amp_en` low, a start seen at a rising edge closes `samp_sw` from that edge for exactly 2*`samp_len`+1 clock cycles (`samp_len` plus one half converter cycle).
- R3: With `amp_en` high, `samp_sw` and `amp_hold` stay low for 2*(`samp_len`+1) cycles after the start edge. Both then stay high together for 2*(`amp_hold_len`+1) cycles. `amp_hold` is never high while `samp_sw` is low.
- R4: The convert phase lasts 2*CONV_CYC cycles after `samp_sw` opens. If `core_done` is high at its end, `rdy` is high for exactly one cycle right after it.
- R5: If `core_done` is low when the convert phase ends, the block waits. `rdy` pulses in the cycle after the first edge at which `core_done` is seen high.
- R6: `cfg_err` is high exactly when `burst_en` is high and `samp_len` is below 12. While it is high, a start request from idle launches no conversion.
- R7: With `freerun_en` high and no configuration error, a new conversion begins in the same cycle as the `rdy` pulse. With `amp_en` low, `samp_sw` is therefore high in that cycle.
- R8: A start request while a conversion is in progress is ignored. The running conversion keeps its timing and produces a single `rdy` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter clock rate |
| rst | input | 1 | Synchronous active-high reset |
| samp_len | input | SW | Programmed sample duration in converter cycles |
| amp_hold_len | input | HW | Amplifier hold duration, held for value+1 converter cycles |
| amp_en | input | 1 | Gain amplifier is in the signal path |
| burst_en | input | 1 | Burst mode, enforces the minimum sample duration |
| freerun_en | input | 1 | Restart a conversion as soon as a result is ready |
| start | input | 1 | Conversion start request |
| core_done | input | 1 | Converter core reports the result complete |
| samp_sw | output | 1 | Sample switch closed |
| amp_hold | output | 1 | Gain amplifier in hold |
| rdy | output | 1 | One-cycle result-ready strobe |
| cfg_err | output | 1 | Illegal configuration: burst with too short a sample duration |

## Verification
The assertions assume that `samp_len`, `amp_hold_len`, `amp_en`, `burst_en` and `freerun_en` stay constant while a conversion is in flight. They also assume that `core_done` is only watched in the cycles where the block waits for it. The bench changes configuration only when the block is idle, apart from turning `freerun_en` off, which it does while a conversion runs. Every start request is driven on the falling clock edge. Stray starts are injected only in the sample and convert phases of a running conversion, where they must be ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CNT_W     = 16;
    localparam int MIN_BURST = 12;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_TRACK = 3'd1,
        PH_XFER  = 3'd2,
        PH_SAMP  = 3'd3,
        PH_CONV  = 3'd4,
        PH_WAIT  = 3'd5
    } phase_e;

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   len_m1;
        logic               load;
    } step_t;

    // Half-cycle window length minus one: n + 1/2 cycles or n + 1 cycles.
    function automatic logic [CNT_W-1:0] win_m1(input logic [CNT_W-1:0] n,
                                                input logic half);
        logic [CNT_W-1:0] dbl;
        dbl = n << 1;
        return half ? dbl : dbl + 1'b1;
    endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg #(
    parameter int SW = 8
) (
    input  logic [SW-1:0] samp_len,
    input  logic          burst_en,
    output logic          cfg_err
);
    import adc_seq_pkg::*;

    localparam logic [SW-1:0] MIN_LEN = SW'(MIN_BURST);

    assign cfg_err = burst_en && (samp_len < MIN_LEN);
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/adc_seq_out.sv
module adc_seq_out (
    input  logic                 clk,
    input  logic                 rst,
    input  adc_seq_pkg::phase_e  ph,
    input  logic                 fin,
    output logic                 samp_sw,
    output logic                 amp_hold,
    output logic                 rdy
);
    import adc_seq_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)
            rdy <= 1'b0;
        else
            rdy <= fin;
    end

    assign samp_sw  = (ph == PH_SAMP) || (ph == PH_XFER);
    assign amp_hold = (ph == PH_XFER);
endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq #(
    parameter int SW       = 8,
    parameter int HW       = 8,
    parameter int CONV_CYC = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] samp_len,
    input  logic [HW-1:0] amp_hold_len,
    input  logic          amp_en,
    input  logic          burst_en,
    input  logic          freerun_en,
    input  logic          start,
    input  logic          core_done,
    output logic          samp_sw,
    output logic          amp_hold,
    output logic          rdy,
    output logic          cfg_err
);
    import adc_seq_pkg::*;

    localparam int               CONV_HC  = 2 * CONV_CYC;
    localparam logic [CNT_W-1:0] CONV_M1  = CNT_W'(CONV_HC - 1);

    phase_e           ph;
    step_t            nxt;
    logic             zero;
    logic             fin;
    logic             busy;
    logic [CNT_W-1:0] len_ext;
    logic [CNT_W-1:0] hold_ext;
    step_t            first;

    assign len_ext  = {{(CNT_W-SW){1'b0}}, samp_len};
    assign hold_ext = {{(CNT_W-HW){1'b0}}, amp_hold_len};
    assign busy     = (ph != PH_IDLE);

    adc_seq_cfg #(.SW(SW)) u_cfg (
        .samp_len (samp_len),
        .burst_en (burst_en),
        .cfg_err  (cfg_err)
    );

    adc_seq_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (nxt.load),
        .load_val (nxt.len_m1),
        .zero     (zero)
    );

    adc_seq_out u_out (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph),
        .fin      (fin),
        .samp_sw  (samp_sw),
        .amp_hold (amp_hold),
        .rdy      (rdy)
    );

    always_comb begin
        first.load = 1'b1;
        if (amp_en) begin
            first.ph     = PH_TRACK;
            first.len_m1 = win_m1(len_ext, 1'b0);
        end else begin
            first.ph     = PH_SAMP;
            first.len_m1 = win_m1(len_ext, 1'b1);
        end
    end

    always_comb begin
        fin = ((ph == PH_CONV) && zero && core_done) ||
              ((ph == PH_WAIT) && core_done);
    end

    always_comb begin
        nxt.ph     = ph;
        nxt.len_m1 = '0;
        nxt.load   = 1'b0;
        case (ph)
            PH_IDLE: begin
                if (start && !cfg_err)
                    nxt = first;
            end
            PH_TRACK: begin
                if (zero) begin
                    nxt.ph     = PH_XFER;
                    nxt.len_m1 = win_m1(hold_ext, 1'b0);
                    nxt.load   = 1'b1;
                end
            end
            PH_XFER, PH_SAMP: begin
                if (zero) begin
                    nxt.ph     = PH_CONV;
                    nxt.len_m1 = CONV_M1;
                    nxt.load   = 1'b1;
                end
            end
            PH_CONV: begin
                if (zero && !core_done)
                    nxt.ph = PH_WAIT;
            end
            PH_WAIT: ;
            default: nxt.ph = PH_IDLE;
        endcase
        if (fin) begin
            if (freerun_en && !cfg_err)
                nxt = first;
            else begin
                nxt.ph   = PH_IDLE;
                nxt.load = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ph <= PH_IDLE;
        else
            ph <= nxt.ph;
    end
endmodule

// File: rtl/adc_phase_seq_chk.sv
module adc_phase_seq_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic freerun_en,
    input logic cfg_err,
    input logic samp_sw,
    input logic amp_hold,
    input logic rdy,
    input logic busy,
    input logic fin
);
    p_rdy_single_r4: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !rdy);

    p_hold_in_switch_r3: assert property (@(posedge clk) disable iff (rst)
        amp_hold |-> samp_sw);

    p_err_no_launch_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_err) |=> !samp_sw && !busy);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !fin) |=> busy && !rdy);

    p_freerun_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (fin && freerun_en && !cfg_err) |=> rdy && busy);

    p_idle_after_rdy_r4: assert property (@(posedge clk) disable iff (rst)
        (fin && !freerun_en) |=> rdy && !busy && !samp_sw);
endmodule

bind adc_phase_seq adc_phase_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .freerun_en (freerun_en),
    .cfg_err    (cfg_err),
    .samp_sw    (samp_sw),
    .amp_hold   (amp_hold),
    .rdy        (rdy),
    .busy       (busy),
    .fin        (fin)
);

// File: tb/adc_phase_seq_bench.sv
module adc_phase_seq_bench;
    localparam int CONV_CYC = 13;
    localparam int CONV_HC  = 2 * CONV_CYC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] samp_len = '0;
    logic [7:0] amp_hold_len = '0;
    logic       amp_en = 1'b0;
    logic       burst_en = 1'b0;
    logic       freerun_en = 1'b0;
    logic       start = 1'b0;
    logic       core_done = 1'b1;
    logic       samp_sw, amp_hold, rdy, cfg_err;

    int n_chk = 0;
    int n_err = 0;

    // measurement results
    int s0, ns, nh, r0, nr, bad_hold, sw_at_r;

    always #10 clk = ~clk;

    adc_phase_seq #(.SW(8), .HW(8), .CONV_CYC(CONV_CYC)) u_adc_phase_seq (
        .clk(clk), .rst(rst), .samp_len(samp_len), .amp_hold_len(amp_hold_len),
        .amp_en(amp_en), .burst_en(burst_en), .freerun_en(freerun_en),
        .start(start), .core_done(core_done), .samp_sw(samp_sw),
        .amp_hold(amp_hold), .rdy(rdy), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    // Sample at falling edges after the start edge; index 0 is the first.
    task automatic measure(input int cycles, input int inj_idx);
        s0 = -1; ns = 0; nh = 0; r0 = -1; nr = 0; bad_hold = 0; sw_at_r = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (samp_sw) begin
                if (s0 < 0) s0 = i;
                ns++;
            end
            if (amp_hold) nh++;
            if (amp_hold && !samp_sw) bad_hold++;
            if (rdy) begin
                if (r0 < 0) begin
                    r0 = i;
                    sw_at_r = samp_sw;
                end
                nr++;
            end
            if (i == inj_idx) start = 1'b1;
        end
        @(negedge clk) start = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 samp_sw", samp_sw, 0);
        check("R1 amp_hold", amp_hold, 0);
        check("R1 rdy", rdy, 0);
    endtask

    task automatic t_plain(input int len);
        samp_len = len[7:0]; amp_en = 0;
        pulse_start();
        measure(2 * len + CONV_HC + 10, -1);
        check("R2 window start", s0, 0);
        check("R2 window length", ns, 2 * len + 1);
        check("R4 rdy index", r0, 2 * len + 1 + CONV_HC);
        check("R4 rdy single", nr, 1);
    endtask

    task automatic t_amp(input int len, input int hl);
        samp_len = len[7:0]; amp_hold_len = hl[7:0]; amp_en = 1;
        pulse_start();
        measure(2 * (len + hl) + CONV_HC + 12, -1);
        check("R3 track length", s0, 2 * (len + 1));
        check("R3 switch length", ns, 2 * (hl + 1));
        check("R3 hold length", nh, 2 * (hl + 1));
        check("R3 hold inside switch", bad_hold, 0);
        check("R4 rdy index amp", r0, s0 + ns + CONV_HC);
        amp_en = 0;
    endtask

    task automatic t_wait_done();
        samp_len = 8'd1; core_done = 0;
        pulse_start();
        measure(3 + CONV_HC + 20, -1);
        check("R5 no rdy while done low", nr, 0);
        check("R5 switch open while waiting", samp_sw, 0);
        core_done = 1;
        @(negedge clk);
        check("R5 rdy after done", rdy, 1);
        @(negedge clk);
        check("R5 rdy one cycle", rdy, 0);
    endtask

    task automatic t_burst_err();
        burst_en = 1; samp_len = 8'd5;
        #1 check("R6 err at 5", cfg_err, 1);
        pulse_start();
        measure(40, -1);
        check("R6 no launch", s0, -1);
        check("R6 no rdy", nr, 0);
        samp_len = 8'd11;
        #1 check("R6 err at 11", cfg_err, 1);
        samp_len = 8'd12;
        #1 check("R6 no err at 12", cfg_err, 0);
        pulse_start();
        measure(25 + CONV_HC + 10, -1);
        check("R6 burst window", ns, 25);
        burst_en = 0;
        #1 check("R6 no err outside burst", cfg_err, 0);
    endtask

    task automatic t_freerun();
        samp_len = 8'd1; freerun_en = 1;
        pulse_start();
        measure(3 + CONV_HC + 2, -1);
        check("R7 rdy index", r0, 3 + CONV_HC);
        check("R7 restart same cycle", sw_at_r, 1);
        freerun_en = 0;
        measure(3 + CONV_HC + 10, -1);
        check("R7 second result", nr, 1);
    endtask

    task automatic t_ignore_start();
        samp_len = 8'd2; amp_en = 0;
        pulse_start();
        measure(2 * 2 + CONV_HC + 10, 2);
        check("R8 window kept (sample)", ns, 5);
        check("R8 rdy kept (sample)", r0, 5 + CONV_HC);
        check("R8 single rdy (sample)", nr, 1);
        pulse_start();
        measure(2 * 2 + CONV_HC + 10, 12);
        check("R8 rdy kept (convert)", r0, 5 + CONV_HC);
        check("R8 single rdy (convert)", nr, 1);
        check("R8 no relaunch", ns, 5);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_plain(2);
        t_plain(0);
        t_amp(3, 2);
        t_amp(0, 0);
        t_wait_done();
        t_burst_err();
        t_freerun();
        t_ignore_start();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule